// File: doc/BRIEF.md
# Energy-Aware Transmit Power Sequencer

This block runs from a slow clock and wakes at a fixed period to decide whether the harvested supply holds enough energy for a radio burst. On each wake-up it requests one conversion of the boosted supply voltage from an ADC. It then compares the returned code against a programmable threshold. When the level is high enough and the packet source reports pending data, it switches on the crystal oscillator and waits a fixed settling interval. It then grants the packet transmitter a fixed-length window. In every other case it goes back to sleep until the next wake-up.

An ADC that does not answer within a bounded number of cycles ends the attempt, and the block treats that as a low-energy verdict. A domain enable output is high for the whole active part of each wake-up. It is meant to drive the power and clock gating of the surrounding blocks, so that they are off between bursts. Every interval is a count of slow-clock cycles set by a parameter.

Top module: `energy_tx_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `adc_req`, `xo_en`, `tx_grant` and `domain_on` are all low.
- R2: A conversion request starts every `PERIOD_CYC` cycles. When each sequence ends inside the period, the rising edges of `adc_req` are exactly `PERIOD_CYC` cycles apart. A wake-up that falls during an active sequence is dropped.
- R3: `adc_req` stays high from the first sampling cycle until the cycle in which `adc_valid` is seen. If valid arrives L cycles after the first request cycle (L below `ADC_TMO_CYC`), the request is high for exactly L+1 cycles.
- R4: If no `adc_valid` arrives within `ADC_TMO_CYC` request cycles, the request drops after exactly `ADC_TMO_CYC` cycles and the oscillator stays off. A valid that arrives after the drop is ignored.
- R5: The energy is sufficient when the captured code, read as unsigned, is greater than or equal to `thresh` and `data_pending` is high. A code equal to the threshold passes.
- R6: A code below the threshold, or `data_pending` low, returns the block to sleep with `xo_en` and `tx_grant` never raised.
- R7: On a sufficient verdict, one decision cycle with all enables low follows the request. After it, `xo_en` is high on its own for exactly `XO_CYC` cycles.
- R8: The transmit window follows the settling interval at once. `tx_grant` is high for exactly `TX_CYC` cycles, `xo_en` stays high throughout, and both fall on the same edge.
- R9: `tx_grant` is never high while `xo_en` is low.
- R10: `domain_on` is high from the first request cycle through the decision cycle, the settling interval and the transmit window. It is low while the block sleeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | ADC_W | Minimum supply code that counts as sufficient |
| data_pending | input | 1 | Packet source has data to send |
| adc_valid | input | 1 | ADC result present on `adc_data` |
| adc_data | input | ADC_W | Digitized boosted supply voltage |
| adc_req | output | 1 | Conversion request, held until valid or timeout |
| xo_en | output | 1 | Crystal oscillator enable |
| tx_grant | output | 1 | Transmit window grant |
| domain_on | output | 1 | Power and clock enable for the surrounding domain |

## Verification
The bench builds the block with `PERIOD_CYC`=64, `XO_CYC`=12, `TX_CYC`=5, `ADC_TMO_CYC`=6 and `ADC_W`=8. A full sequence takes at most 24 cycles, so every wake-up starts a sequence and each period can be measured exactly. This brings the timeout edge within reach: an ADC answer at the last allowed cycle is accepted, and one a cycle later is ignored. The 12 and 5 cycle windows are short enough to count over many randomly drawn attempts. With an 8-bit code the equal-to-threshold and one-below cases can be driven on purpose, next to random codes, latencies and pending flags.

// File: rtl/etx_pkg.sv
package etx_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_SAMPLE  = 3'd1,
    ST_DECIDE  = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_SEND    = 3'd4
  } seq_state_t;
endpackage

// File: rtl/etx_tick_gen.sv
module etx_tick_gen #(
  parameter int PERIOD_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] WRAP = PW'(PERIOD_CYC - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == WRAP) ? '0 : cnt_q + 1'b1;
      tick  <= (cnt_q == WRAP);
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2
endmodule

// File: rtl/etx_dwell_timer.sv
module etx_dwell_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (!last)   cnt_q <= cnt_q + 1'b1;
  end

  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (last && !clear) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/etx_fsm.sv
module etx_fsm
  import etx_pkg::*;
#(
  parameter int ADC_W       = 8,
  parameter int XO_CYC      = 12,
  parameter int TX_CYC      = 5,
  parameter int ADC_TMO_CYC = 6,
  parameter int CW          = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ADC_W-1:0] thresh,
  input  logic             data_pending,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             dwell_last,
  output logic             dwell_clear,
  output logic [CW-1:0]    dwell_limit,
  output logic             adc_req,
  output logic             xo_en,
  output logic             tx_grant,
  output logic             domain_on
);
  seq_state_t state_q, state_n;
  logic [ADC_W-1:0] code_q;
  logic             enough;

  assign enough = (code_q >= thresh) && data_pending;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_SLEEP:  if (tick) state_n = ST_SAMPLE;
      ST_SAMPLE: begin
        if (adc_valid)       state_n = ST_DECIDE;
        else if (dwell_last) state_n = ST_SLEEP;
      end
      ST_DECIDE: state_n = enough ? ST_SETTLE : ST_SLEEP;
      ST_SETTLE: if (dwell_last) state_n = ST_SEND;
      ST_SEND:   if (dwell_last) state_n = ST_SLEEP;
      default:   state_n = ST_SLEEP;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_SAMPLE: dwell_limit = CW'(ADC_TMO_CYC);
      ST_SETTLE: dwell_limit = CW'(XO_CYC);
      ST_SEND:   dwell_limit = CW'(TX_CYC);
      default:   dwell_limit = CW'(1);
    endcase
  end

  assign dwell_clear = (state_n != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_SLEEP;
      code_q    <= '0;
      adc_req   <= 1'b0;
      xo_en     <= 1'b0;
      tx_grant  <= 1'b0;
      domain_on <= 1'b0;
    end else begin
      state_q   <= state_n;
      if (state_q == ST_SAMPLE && adc_valid) code_q <= adc_data;
      adc_req   <= (state_n == ST_SAMPLE);
      xo_en     <= (state_n == ST_SETTLE) || (state_n == ST_SEND);
      tx_grant  <= (state_n == ST_SEND);
      domain_on <= (state_n != ST_SLEEP);
    end
  end

  AST_TMO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SAMPLE && !adc_valid && dwell_last) |=> (state_q == ST_SLEEP)); // R4
  AST_LOW_ENERGY_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECIDE && code_q < thresh) |=> (state_q == ST_SLEEP)); // R6
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_req) |-> $past(state_q == ST_SLEEP)); // R2
endmodule

// File: rtl/energy_tx_sequencer.sv
module energy_tx_sequencer #(
  parameter int PERIOD_CYC  = 163840,
  parameter int XO_CYC      = 655,
  parameter int TX_CYC      = 22,
  parameter int ADC_TMO_CYC = 16,
  parameter int ADC_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADC_W-1:0] thresh,
  input  logic             data_pending,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  output logic             adc_req,
  output logic             xo_en,
  output logic             tx_grant,
  output logic             domain_on
);
  localparam int MAX_A   = (XO_CYC > TX_CYC) ? XO_CYC : TX_CYC;
  localparam int MAX_DW  = (MAX_A > ADC_TMO_CYC) ? MAX_A : ADC_TMO_CYC;
  localparam int CW      = $clog2(MAX_DW + 1);

  logic          tick;
  logic          dwell_last;
  logic          dwell_clear;
  logic [CW-1:0] dwell_limit;

  etx_tick_gen #(.PERIOD_CYC(PERIOD_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  etx_dwell_timer #(.CW(CW)) u_dwell (
    .clk   (clk),
    .rst   (rst),
    .clear (dwell_clear),
    .limit (dwell_limit),
    .last  (dwell_last)
  );

  etx_fsm #(
    .ADC_W       (ADC_W),
    .XO_CYC      (XO_CYC),
    .TX_CYC      (TX_CYC),
    .ADC_TMO_CYC (ADC_TMO_CYC),
    .CW          (CW)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .thresh       (thresh),
    .data_pending (data_pending),
    .adc_valid    (adc_valid),
    .adc_data     (adc_data),
    .dwell_last   (dwell_last),
    .dwell_clear  (dwell_clear),
    .dwell_limit  (dwell_limit),
    .adc_req      (adc_req),
    .xo_en        (xo_en),
    .tx_grant     (tx_grant),
    .domain_on    (domain_on)
  );

  AST_GRANT_NEEDS_XO: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> xo_en); // R9
  AST_GRANT_AFTER_XO: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_grant) |-> $past(xo_en)); // R8
  AST_XO_DROPS_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_grant) |-> !xo_en); // R8
  AST_REQ_XO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(adc_req && xo_en)); // R7
  AST_DOMAIN_COVERS: assert property (@(posedge clk) disable iff (rst)
    (adc_req || xo_en) |-> domain_on); // R10
endmodule

// File: tb/energy_tx_sequencer_test.sv
module energy_tx_sequencer_test;
  localparam int PERIOD = 64;
  localparam int XO     = 12;
  localparam int TX     = 5;
  localparam int TMO    = 6;
  localparam int AW     = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] thresh = '0;
  logic          data_pending = 1'b0;
  logic          adc_valid = 1'b0;
  logic [AW-1:0] adc_data = '0;
  logic          adc_req, xo_en, tx_grant, domain_on;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rise = -1;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  energy_tx_sequencer #(
    .PERIOD_CYC(PERIOD), .XO_CYC(XO), .TX_CYC(TX),
    .ADC_TMO_CYC(TMO), .ADC_W(AW)
  ) uut (
    .clk(clk), .rst(rst), .thresh(thresh), .data_pending(data_pending),
    .adc_valid(adc_valid), .adc_data(adc_data), .adc_req(adc_req),
    .xo_en(xo_en), .tx_grant(tx_grant), .domain_on(domain_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit expect_go(input int code, input int thr, input bit pend);
    return (code >= thr) && pend;
  endfunction

  // R9: grant never without oscillator, checked every cycle
  always @(negedge clk) begin
    if (!rst && tx_grant && !xo_en) chk(1'b0, "R9", 0, 1);
  end

  task automatic attempt(input int lat, input int code, input int thr, input bit pend);
    int n_req, n_xo, n_tx;
    bit accepted, go;
    thresh       = AW'(thr);
    data_pending = pend;
    accepted     = (lat < TMO);
    go           = accepted && expect_go(code, thr, pend);
    do @(negedge clk); while (!adc_req);
    if (last_rise >= 0) chk(cyc - last_rise == PERIOD, "R2", cyc - last_rise, PERIOD);
    last_rise = cyc;
    chk(domain_on, "R10", domain_on, 1);
    fork
      begin
        repeat (lat) @(negedge clk);
        adc_valid = 1'b1;
        adc_data  = AW'(code);
        @(negedge clk);
        adc_valid = 1'b0;
      end
    join_none
    n_req = 1;
    @(negedge clk);
    while (adc_req) begin n_req++; @(negedge clk); end
    if (accepted) chk(n_req == lat + 1, "R3", n_req, lat + 1);
    else          chk(n_req == TMO, "R4", n_req, TMO);
    if (!accepted) begin
      chk(!xo_en && !domain_on, "R4", {xo_en, domain_on}, 0);
      repeat (lat - TMO + 2) @(negedge clk);
      chk(!xo_en && !tx_grant, "R4", {xo_en, tx_grant}, 0);
    end else begin
      chk(domain_on && !xo_en, "R10", {domain_on, xo_en}, 2);
      @(negedge clk);
      if (!go) begin
        chk(!xo_en && !domain_on, expect_go(code, thr, 1'b1) ? "R6" : "R5",
            {xo_en, domain_on}, 0);
      end else begin
        n_xo = 0; n_tx = 0;
        while (xo_en && !tx_grant) begin
          n_xo++;
          if (!domain_on) chk(1'b0, "R10", 0, 1);
          @(negedge clk);
        end
        while (xo_en && tx_grant) begin n_tx++; @(negedge clk); end
        chk(n_xo == XO, "R7", n_xo, XO);
        chk(n_tx == TX, "R8", n_tx, TX);
        chk(!xo_en && !tx_grant && !domain_on, "R8", {xo_en, tx_grant, domain_on}, 0);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({adc_req, xo_en, tx_grant, domain_on} == 4'b0, "R1",
        {adc_req, xo_en, tx_grant, domain_on}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({adc_req, xo_en, tx_grant, domain_on} == 4'b0, "R1",
        {adc_req, xo_en, tx_grant, domain_on}, 0);

    attempt(2, 100, 100, 1'b1);        // R5 equal passes
    attempt(1, 99, 100, 1'b1);         // R6 one below
    attempt(0, 200, 50, 1'b0);         // R6 no data
    attempt(TMO - 1, 255, 0, 1'b1);    // R3 last allowed cycle
    attempt(TMO, 255, 0, 1'b1);        // R4 late valid ignored
    attempt(TMO + 2, 255, 0, 1'b1);    // R4 no answer
    attempt(0, 0, 0, 1'b1);            // R5 zero code, zero threshold
    for (int i = 0; i < 24; i++) begin
      attempt(int'($urandom_range(TMO + 1, 0)), int'($urandom_range(255, 0)),
              int'($urandom_range(255, 0)), 1'($urandom_range(1, 0) | $urandom_range(1, 0)));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule